// File: doc/BRIEF.md
# Up/Down Pulse Counter

This block is a small counter whose direction is set by which of two count inputs receives a rising edge. A low-to-high transition on the up input adds one, and a low-to-high transition on the down input subtracts one. In each case the other input must be resting high. A parameter picks decade sequencing (0 to 9) or full binary sequencing (0 to 2^WIDTH-1). A free-running system clock synchronises both count inputs and finds their rising edges, so the inputs may come from any source that holds each level for a few clock periods.

An active-low load input passes the data inputs straight to the count output while it is low, and the register captures that value. An active-high clear forces zero and wins over load and counting. Both act on the output in the same cycle they are applied, without waiting for a clock edge. Two active-low terminal outputs let stages be chained with no glue logic. The up terminal of one stage goes low at the top value while its up input is low. The down terminal goes low at zero while its down input is low. When the input returns high, each terminal gives a rising edge that the next stage counts on its matching input.

Top module: `updown_pulse_counter`

## Requirements
- R1: A rising edge on `up_i` while `dn_i` rests high adds one to the count, wrapping from the top value to 0. The new value appears after the third `clk` rising edge that follows the `up_i` rise, and not before.
- R2: A rising edge on `dn_i` while `up_i` rests high subtracts one, wrapping from 0 to the top value, with the same latency as R1.
- R3: A rising edge on one count input while the other is low leaves the count unchanged and does not set `err_o`.
- R4: When both count inputs rise in the same sample, the count holds and `err_o` goes to 1. The flag stays at 1 through later good counts until clear, load or reset.
- R5: While `load_n_i` is 0, `q_o` equals `d_i` in the same cycle and follows any change of `d_i`. Count edges in that time are dropped. Load also returns `err_o` to 0.
- R6: After `load_n_i` returns to 1 the count keeps the loaded value, and the next count edge steps from it.
- R7: While `load_n_i` is 1, changes on `d_i` do not alter `q_o`.
- R8: While `clr_i` is 1, `q_o` is 0 in the same cycle, regardless of load and count inputs, and `err_o` returns to 0. The count stays at 0 when clear and load are released together.
- R9: With DECADE=1 the count runs 0..9, so 9 steps up to 0 and 0 steps down to 9. With DECADE=0 it runs 0..15 for WIDTH=4.
- R10: In decade mode, a loaded value of 10..15 moves to 0 on an up step and to 9 on a down step.
- R11: `carry_n_o` is 0 exactly when `q_o` is the top value and `up_i` is 0. `borrow_n_o` is 0 exactly when `q_o` is 0 and `dn_i` is 0.
- R12: A second stage driven by the first stage's `carry_n_o` and `borrow_n_o` counts the decades. Ten up steps from 0 give high=1 and low=0. One further down step gives high=0 and low=9.
- R13: Synchronous active-high `rst` sets the count to 0 and `err_o` to 0. With idle-high count inputs, both terminal outputs are 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Active-high master clear, overrides all |
| load_n_i | input | 1 | Active-low parallel load |
| d_i | input | WIDTH | Parallel load data |
| up_i | input | 1 | Count-up input, counts on rising edge |
| dn_i | input | 1 | Count-down input, counts on rising edge |
| q_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Active-low up terminal, feeds next stage `up_i` |
| borrow_n_o | output | 1 | Active-low down terminal, feeds next stage `dn_i` |
| err_o | output | 1 | Registered flag for a simultaneous up/down edge |

## Verification
Clear, load, data and the terminal outputs act on the outputs within the cycle they are applied. The bench therefore samples them at the next falling edge after driving. A count step and the error flag land on the third rising clock edge after the count input rises: two synchroniser stages, then the count register. One scenario samples after the second and after the third edge to pin that latency exactly. All other scenarios hold each count level for four clock periods before sampling, so the step has settled. The cascade scenario adds no extra margin, because the second stage sees the first stage's terminal edge at the same moment the first stage's input rises.

// File: rtl/upc_pkg.sv
package upc_pkg;

  typedef struct packed {
    logic inc;
    logic dec;
    logic both;
  } step_t;

  function automatic int top_value(input int width, input bit decade);
    return decade ? 9 : ((1 << width) - 1);
  endfunction

endpackage

// File: rtl/upc_edge_sense.sv
module upc_edge_sense #(
  parameter int CHANNELS = 2,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHANNELS-1:0] raw_i,
  output logic [CHANNELS-1:0] lvl_o,
  output logic [CHANNELS-1:0] rise_o
);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic [STAGES-1:0] sh;
    logic              prev;

    // idle-high reset value so that leaving reset never looks like a rise
    always_ff @(posedge clk) begin
      if (rst) begin
        sh   <= '1;
        prev <= 1'b1;
      end else begin
        sh   <= (sh << 1) | STAGES'(raw_i[c]);
        prev <= sh[STAGES-1];
      end
    end

    assign lvl_o[c]  = sh[STAGES-1];
    assign rise_o[c] = sh[STAGES-1] & ~prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      rise_o[c] |=> !rise_o[c]); // R1
  end

endmodule

// File: rtl/upc_count_core.sv
module upc_count_core
  import upc_pkg::*;
#(
  parameter int W      = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         load_n_i,
  input  logic [W-1:0] d_i,
  input  logic         lvl_up_i,
  input  logic         lvl_dn_i,
  input  logic         rise_up_i,
  input  logic         rise_dn_i,
  output logic [W-1:0] cnt_o,
  output logic         err_o
);

  localparam logic [W-1:0] TOP = W'(top_value(W, DECADE));

  step_t        step;
  logic [W-1:0] cnt_q;
  logic [W-1:0] nxt_up;
  logic [W-1:0] nxt_dn;
  logic         err_q;

  always_comb begin
    step.inc  = rise_up_i & lvl_dn_i & ~rise_dn_i;
    step.dec  = rise_dn_i & lvl_up_i & ~rise_up_i;
    step.both = rise_up_i & rise_dn_i;
  end

  // out-of-range values (decade mode) step to a legal end of the range
  always_comb begin
    nxt_up = (cnt_q >= TOP) ? '0 : cnt_q + 1'b1;
    if (cnt_q == '0 || cnt_q > TOP) nxt_dn = TOP;
    else                            nxt_dn = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (!load_n_i) begin
      cnt_q <= d_i;
      err_q <= 1'b0;
    end else if (step.both) begin
      err_q <= 1'b1;
    end else if (step.inc) begin
      cnt_q <= nxt_up;
    end else if (step.dec) begin
      cnt_q <= nxt_dn;
    end
  end

  assign cnt_o = cnt_q;
  assign err_o = err_q;

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    step.inc && !clr_i && load_n_i && (cnt_q < TOP) |=> cnt_q == W'($past(cnt_q) + 1'b1)); // R1
  AST_DN_STEP: assert property (@(posedge clk) disable iff (rst)
    step.dec && !clr_i && load_n_i && (cnt_q != '0) && (cnt_q <= TOP) |=> cnt_q == W'($past(cnt_q) - 1'b1)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step.inc && !step.dec && !clr_i && load_n_i |=> $stable(cnt_q)); // R3
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    step.both && !clr_i && load_n_i |=> $stable(cnt_q) && err_q); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0) && !err_q); // R8
  AST_LEGAL_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    (step.inc || step.dec) && !clr_i && load_n_i |=> cnt_q <= TOP); // R10

endmodule

// File: rtl/upc_term_out.sv
module upc_term_out
  import upc_pkg::*;
#(
  parameter int W      = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] q_i,
  input  logic         up_i,
  input  logic         dn_i,
  output logic         carry_n_o,
  output logic         borrow_n_o
);

  localparam logic [W-1:0] TOP = W'(top_value(W, DECADE));

  logic at_top;
  logic at_zero;

  assign at_top     = (q_i == TOP);
  assign at_zero    = (q_i == '0);
  assign carry_n_o  = ~(at_top & ~up_i);
  assign borrow_n_o = ~(at_zero & ~dn_i);

  AST_TERM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!carry_n_o && !borrow_n_o)); // R11

endmodule

// File: rtl/updown_pulse_counter.sv
module updown_pulse_counter #(
  parameter int WIDTH       = 4,
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [WIDTH-1:0] q_o,
  output logic             carry_n_o,
  output logic             borrow_n_o,
  output logic             err_o
);

  localparam int CH_UP = 0;
  localparam int CH_DN = 1;

  logic [1:0]       lvl;
  logic [1:0]       rise;
  logic [WIDTH-1:0] cnt;

  upc_edge_sense #(
    .CHANNELS (2),
    .STAGES   (SYNC_STAGES)
  ) u_edge (
    .clk    (clk),
    .rst    (rst),
    .raw_i  ({dn_i, up_i}),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  upc_count_core #(
    .W      (WIDTH),
    .DECADE (DECADE)
  ) u_core (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (clr_i),
    .load_n_i  (load_n_i),
    .d_i       (d_i),
    .lvl_up_i  (lvl[CH_UP]),
    .lvl_dn_i  (lvl[CH_DN]),
    .rise_up_i (rise[CH_UP]),
    .rise_dn_i (rise[CH_DN]),
    .cnt_o     (cnt),
    .err_o     (err_o)
  );

  // clear and load reach the output without waiting for a clock edge
  assign q_o = clr_i ? '0 : (!load_n_i ? d_i : cnt);

  upc_term_out #(
    .W      (WIDTH),
    .DECADE (DECADE)
  ) u_term (
    .clk        (clk),
    .rst        (rst),
    .q_i        (q_o),
    .up_i       (up_i),
    .dn_i       (dn_i),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o)
  );

endmodule

// File: tb/test_updown_pulse_counter.sv
module test_updown_pulse_counter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] d = 4'd0;
  logic       up_a = 1'b1, dn_a = 1'b1;
  logic       up_b = 1'b1, dn_b = 1'b1;
  logic [3:0] q_a, q_hi, q_b;
  logic       carry_a, borrow_a, err_a;
  logic       carry_hi, borrow_hi, err_hi;
  logic       carry_b, borrow_b, err_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  updown_pulse_counter #(.WIDTH(4), .DECADE(1'b1), .SYNC_STAGES(2)) i_updown_pulse_counter (
    .clk(clk), .rst(rst), .clr_i(clr), .load_n_i(load_n), .d_i(d),
    .up_i(up_a), .dn_i(dn_a), .q_o(q_a),
    .carry_n_o(carry_a), .borrow_n_o(borrow_a), .err_o(err_a));

  updown_pulse_counter #(.WIDTH(4), .DECADE(1'b1), .SYNC_STAGES(2)) i_updown_pulse_counter_hi (
    .clk(clk), .rst(rst), .clr_i(clr), .load_n_i(load_n), .d_i(d),
    .up_i(carry_a), .dn_i(borrow_a), .q_o(q_hi),
    .carry_n_o(carry_hi), .borrow_n_o(borrow_hi), .err_o(err_hi));

  updown_pulse_counter #(.WIDTH(4), .DECADE(1'b0), .SYNC_STAGES(2)) i_updown_pulse_counter_bin (
    .clk(clk), .rst(rst), .clr_i(clr), .load_n_i(load_n), .d_i(d),
    .up_i(up_b), .dn_i(dn_b), .q_o(q_b),
    .carry_n_o(carry_b), .borrow_n_o(borrow_b), .err_o(err_b));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_a_up();
    up_a = 1'b0; tick(4); up_a = 1'b1; tick(4);
  endtask

  task automatic pulse_a_dn();
    dn_a = 1'b0; tick(4); dn_a = 1'b1; tick(4);
  endtask

  task automatic pulse_b_up();
    up_b = 1'b0; tick(4); up_b = 1'b1; tick(4);
  endtask

  task automatic pulse_b_dn();
    dn_b = 1'b0; tick(4); dn_b = 1'b1; tick(4);
  endtask

  task automatic clear_all();
    clr = 1'b1; tick(2); clr = 1'b0; tick(2);
  endtask

  task automatic t_reset();
    tick(3); rst = 1'b0; tick(1);
    chk("R13 q after reset", q_a, 0);
    chk("R13 err after reset", err_a, 0);
    chk("R13 carry idle", carry_a, 1);
    chk("R13 borrow idle", borrow_a, 1);
    chk("R13 binary q after reset", q_b, 0);
  endtask

  task automatic t_count_up();
    pulse_a_up(); pulse_a_up();
    chk("R1 two up steps", q_a, 2);
    up_a = 1'b0; tick(4);
    up_a = 1'b1; tick(2);
    chk("R1 not yet after second edge", q_a, 2);
    tick(1);
    chk("R1 due after third edge", q_a, 3);
    tick(3);
  endtask

  task automatic t_count_down();
    pulse_a_up(); pulse_a_dn();
    chk("R2 down step", q_a, 3);
  endtask

  task automatic t_blocked();
    dn_a = 1'b0; tick(4);
    pulse_a_up();
    chk("R3 up edge with down low", q_a, 3);
    chk("R3 no error", err_a, 0);
    dn_a = 1'b1; tick(4);
    chk("R2 down edge on release", q_a, 2);
  endtask

  task automatic t_both();
    up_a = 1'b0; dn_a = 1'b0; tick(4);
    up_a = 1'b1; dn_a = 1'b1; tick(4);
    chk("R4 count holds", q_a, 2);
    chk("R4 error set", err_a, 1);
    pulse_a_up();
    chk("R4 later step counts", q_a, 3);
    chk("R4 error sticky", err_a, 1);
  endtask

  task automatic t_load();
    d = 4'd7; load_n = 1'b0; tick(1);
    chk("R5 load passes data", q_a, 7);
    chk("R5 load clears error", err_a, 0);
    d = 4'd5; tick(1);
    chk("R5 follows data", q_a, 5);
    d = 4'd7; tick(1);
    pulse_a_up();
    chk("R5 count ignored in load", q_a, 7);
    load_n = 1'b1; tick(2);
    chk("R6 keeps loaded value", q_a, 7);
    pulse_a_up();
    chk("R6 steps from load", q_a, 8);
  endtask

  task automatic t_data_ignored();
    d = 4'd2; tick(3);
    chk("R7 data ignored", q_a, 8);
  endtask

  task automatic t_decade_wrap();
    pulse_a_up();
    chk("R9 reach nine", q_a, 9);
    chk("R11 carry high while up high", carry_a, 1);
    up_a = 1'b0; tick(1);
    chk("R11 carry low at top", carry_a, 0);
    tick(3);
    up_a = 1'b1; tick(1);
    chk("R11 carry rises", carry_a, 1);
    tick(3);
    chk("R9 up wrap to zero", q_a, 0);
    chk("R12 high stage counts up", q_hi, 8);
    dn_a = 1'b0; tick(1);
    chk("R11 borrow low at zero", borrow_a, 0);
    tick(3);
    dn_a = 1'b1; tick(4);
    chk("R9 down wrap to nine", q_a, 9);
    chk("R12 high stage counts down", q_hi, 7);
  endtask

  task automatic t_illegal();
    d = 4'd12; load_n = 1'b0; tick(2); load_n = 1'b1; tick(2);
    pulse_a_up();
    chk("R10 12 up goes to 0", q_a, 0);
    d = 4'd13; load_n = 1'b0; tick(2); load_n = 1'b1; tick(2);
    pulse_a_dn();
    chk("R10 13 down goes to 9", q_a, 9);
  endtask

  task automatic t_clear();
    up_a = 1'b0; dn_a = 1'b0; tick(4);
    up_a = 1'b1; dn_a = 1'b1; tick(4);
    chk("R4 error before clear", err_a, 1);
    d = 4'd6; load_n = 1'b0; clr = 1'b1; up_a = 1'b0; tick(1);
    chk("R8 clear beats load", q_a, 0);
    up_a = 1'b1; tick(4);
    chk("R8 clear beats count", q_a, 0);
    chk("R8 clear resets error", err_a, 0);
    clr = 1'b0; load_n = 1'b1; tick(4);
    chk("R8 zero after release", q_a, 0);
  endtask

  task automatic t_cascade();
    clear_all();
    for (int i = 0; i < 10; i++) pulse_a_up();
    chk("R12 low digit after ten", q_a, 0);
    chk("R12 high digit after ten", q_hi, 1);
    pulse_a_dn();
    chk("R12 low digit after borrow", q_a, 9);
    chk("R12 high digit after borrow", q_hi, 0);
  endtask

  task automatic t_binary();
    clear_all();
    d = 4'd14; load_n = 1'b0; tick(2); load_n = 1'b1; tick(2);
    pulse_b_up();
    chk("R9 binary reaches 15", q_b, 15);
    up_b = 1'b0; tick(1);
    chk("R11 binary carry low at 15", carry_b, 0);
    tick(3); up_b = 1'b1; tick(4);
    chk("R9 binary wraps to 0", q_b, 0);
    pulse_b_dn();
    chk("R9 binary 0 down to 15", q_b, 15);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    t_reset();
    t_count_up();
    t_count_down();
    t_blocked();
    t_both();
    t_load();
    t_data_ignored();
    t_decade_wrap();
    t_illegal();
    t_clear();
    t_cascade();
    t_binary();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

endmodule